// File: doc/BRIEF.md
# Audio Bit-Clock and Master-Clock Generator

This block divides a fast source clock down to the serial bit clock of an audio serial port. It can also produce an oversampled master clock for an external converter. A prescaler divides the source clock by an even or odd ratio, set by an 8-bit divide value and an odd-ratio bit. With the master clock disabled, the prescaler output drives the bit-clock pin directly. With the master clock enabled, the prescaler output drives the master-clock pin, and the bit clock is taken from it through a second fixed divide. That divide is 8 or 4, chosen by the channel-length bit. The sample rate then follows as the bit rate divided by (bits per channel × channel count).

Every output is a flip-flop, so nothing switches mid-cycle. Alongside the bit clock the block gives a one-cycle tick in the source-clock domain, which a serializer uses as its shift strobe. The configuration must stay constant while the enable is high. To change it, clear the enable, which returns every counter and output to zero. A divide value below 2 is replaced by 2, and an error flag shows this.

Top module: `aud_clkgen`

## Requirements
- R1: With `mck_on` = 0, `bclk` has a period of N = 2·D + `odd_ratio` source cycles, where D is `div_val` (or 2 when `div_val` < 2).
- R2: The prescaled clock is high for D + `odd_ratio` source cycles and low for D cycles. An odd ratio therefore makes the high phase one cycle longer than the low phase.
- R3: With `mck_on` = 1 and `long_chan` = 0, `bclk` has a period of 8·N cycles, with equal high and low phases of 4·N cycles.
- R4: With `mck_on` = 1 and `long_chan` = 1, `bclk` has a period of 4·N cycles, with equal high and low phases of 2·N cycles.
- R5: `mclk` carries the prescaled clock (period N, phases as in R2) only while `mck_on` = 1. It is held at 0 while `mck_on` = 0.
- R6: After `en` rises, all outputs stay low, and the first rising edge of `bclk` (and of `mclk`, when it is on) appears N source cycles after the first clock edge that samples `en` high.
- R7: `bit_tick` is high for exactly one source cycle, in the same cycle as each rising edge of `bclk`, and is low at all other times.
- R8: While `en` = 1 and `div_val` < 2, the block divides as if `div_val` were 2 and raises `cfg_err` one cycle later. With a legal divide value, `cfg_err` is 0.
- R9: Synchronous `rst`, or `en` = 0, sets `bclk`, `mclk`, `bit_tick` and `cfg_err` to 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears all state |
| div_val | input | 8 | Divide value D (ratio 2·D + odd) |
| odd_ratio | input | 1 | Adds one source cycle to the ratio |
| mck_on | input | 1 | Master-clock output enable; adds the post divide |
| long_chan | input | 1 | Channel-length select: 0 gives post divide 8, 1 gives 4 |
| bclk | output | 1 | Serial bit clock |
| mclk | output | 1 | Master clock (0 when disabled) |
| bit_tick | output | 1 | One-cycle pulse at each bit-clock rise |
| cfg_err | output | 1 | Divide value below the legal minimum |

## Verification
The hardest case to reach from the ports is the full post-divided bit clock at the largest ratios. Its phases last hundreds of source cycles, and its first edge depends on both counters leaving reset in step. Each directed scenario therefore parks the configuration with `en` low and then raises `en` on a known cycle. From that cycle it counts source cycles to the first `bclk` rise, then through one high and one low phase. Over the same window it counts the `mclk` high cycles and the `bit_tick` pulses. Scenarios cover all four enable/length combinations, with even, odd and maximum ratios and two clamped divide values.

// File: rtl/aud_clkgen_pkg.sv
`timescale 1ns/1ps
package aud_clkgen_pkg;
  // smallest legal divide value; smaller settings are clamped to it
  parameter int unsigned AUD_MIN_DIV   = 2;
  // post-divide factors applied to the bit clock when the master clock runs
  parameter int unsigned AUD_MUL_SHORT = 8;
  parameter int unsigned AUD_MUL_LONG  = 4;

  typedef enum logic {
    BCLK_FROM_PRESCALER = 1'b0,
    BCLK_FROM_POSTDIV   = 1'b1
  } bclk_src_e;
endpackage

// File: rtl/aud_clk_prescaler.sv
`timescale 1ns/1ps
module aud_clk_prescaler #(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned MIN_DIV = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  input  logic             odd_ratio,
  output logic             wrap,
  output logic             armed,
  output logic             armed_nxt,
  output logic             pre_nxt
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [DIV_W-1:0] div_eff;
  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] hi_len;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    div_eff   = (div_val < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_val;
    ratio     = {div_eff, 1'b0} + CNT_W'(odd_ratio);
    hi_len    = CNT_W'(div_eff) + CNT_W'(odd_ratio);
    wrap      = en && (cnt == ratio - CNT_W'(1));
    cnt_nxt   = !en ? '0 : (wrap ? '0 : cnt + CNT_W'(1));
    armed_nxt = en && (armed || wrap);
    // high phase covers count values 0 .. hi_len-1 of every armed period
    pre_nxt   = armed_nxt && (cnt_nxt < hi_len);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      armed <= armed_nxt;
    end
  end
endmodule

// File: rtl/aud_clk_postdiv.sv
`timescale 1ns/1ps
module aud_clk_postdiv #(
  parameter int unsigned MUL_SHORT = 8,
  parameter int unsigned MUL_LONG  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic long_chan,
  input  logic wrap,
  input  logic armed,
  input  logic armed_nxt,
  output logic post_nxt
);
  localparam int unsigned SUB_W = $clog2(MUL_SHORT);
  localparam logic [SUB_W:0] K_SHORT = (SUB_W+1)'(MUL_SHORT);
  localparam logic [SUB_W:0] K_LONG  = (SUB_W+1)'(MUL_LONG);

  logic [SUB_W:0] k_sel;
  logic [SUB_W:0] sub;
  logic [SUB_W:0] sub_nxt;

  always_comb begin
    k_sel = long_chan ? K_LONG : K_SHORT;
    if (!en)
      sub_nxt = '0;
    else if (wrap && armed)
      sub_nxt = (sub == k_sel - (SUB_W+1)'(1)) ? '0 : sub + (SUB_W+1)'(1);
    else
      sub_nxt = sub;
    // first half of the prescaled periods in each group is the high phase
    post_nxt = armed_nxt && (sub_nxt < (k_sel >> 1));
  end

  always_ff @(posedge clk) begin
    if (rst) sub <= '0;
    else     sub <= sub_nxt;
  end
endmodule

// File: rtl/aud_clkgen.sv
`timescale 1ns/1ps
module aud_clkgen
  import aud_clkgen_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  input  logic             odd_ratio,
  input  logic             mck_on,
  input  logic             long_chan,
  output logic             bclk,
  output logic             mclk,
  output logic             bit_tick,
  output logic             cfg_err
);
  logic      wrap, armed, armed_nxt, pre_nxt, post_nxt;
  logic      bclk_nxt;
  bclk_src_e src;

  aud_clk_prescaler #(
    .DIV_W   (DIV_W),
    .MIN_DIV (AUD_MIN_DIV)
  ) u_pre (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .div_val   (div_val),
    .odd_ratio (odd_ratio),
    .wrap      (wrap),
    .armed     (armed),
    .armed_nxt (armed_nxt),
    .pre_nxt   (pre_nxt)
  );

  aud_clk_postdiv #(
    .MUL_SHORT (AUD_MUL_SHORT),
    .MUL_LONG  (AUD_MUL_LONG)
  ) u_post (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .long_chan (long_chan),
    .wrap      (wrap),
    .armed     (armed),
    .armed_nxt (armed_nxt),
    .post_nxt  (post_nxt)
  );

  always_comb begin
    src      = mck_on ? BCLK_FROM_POSTDIV : BCLK_FROM_PRESCALER;
    bclk_nxt = (src == BCLK_FROM_POSTDIV) ? post_nxt : pre_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk     <= 1'b0;
      mclk     <= 1'b0;
      bit_tick <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      bclk     <= bclk_nxt;
      mclk     <= mck_on && pre_nxt;
      bit_tick <= bclk_nxt && !bclk;
      cfg_err  <= en && (div_val < DIV_W'(AUD_MIN_DIV));
    end
  end
endmodule

// File: rtl/aud_clkgen_chk.sv
`timescale 1ns/1ps
module aud_clkgen_chk #(
  parameter int unsigned DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [DIV_W-1:0] div_val,
  input logic             mck_on,
  input logic             bclk,
  input logic             mclk,
  input logic             bit_tick,
  input logic             cfg_err
);
  AST_TICK_WITH_BCLK: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> (bclk && !$past(bclk)));                              // R7
  AST_RISE_HAS_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(bclk) |-> bit_tick);                                         // R7
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick);                                           // R7
  AST_MCLK_GATED: assert property (@(posedge clk) disable iff (rst)
    !$past(mck_on) |-> !mclk);                                         // R5
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!bclk && !mclk && !bit_tick && !cfg_err));         // R9
  AST_CLAMP_FLAG: assert property (@(posedge clk) disable iff (rst)
    (en && (div_val < DIV_W'(2))) |=> cfg_err);                        // R8
  AST_MCLK_MIN_HIGH: assert property (@(posedge clk) disable iff (rst)
    ($rose(mclk) && $past(en)) |=> (mclk || !$past(en)));              // R8
endmodule

bind aud_clkgen aud_clkgen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .div_val  (div_val),
  .mck_on   (mck_on),
  .bclk     (bclk),
  .mclk     (mclk),
  .bit_tick (bit_tick),
  .cfg_err  (cfg_err)
);

// File: tb/aud_clkgen_bench.sv
`timescale 1ns/1ps
module aud_clkgen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [7:0] div_val = 8'd2;
  logic       odd_ratio = 1'b0;
  logic       mck_on = 1'b0;
  logic       long_chan = 1'b0;
  logic       bclk, mclk, bit_tick, cfg_err;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  aud_clkgen u_aud_clkgen (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .div_val   (div_val),
    .odd_ratio (odd_ratio),
    .mck_on    (mck_on),
    .long_chan (long_chan),
    .bclk      (bclk),
    .mclk      (mclk),
    .bit_tick  (bit_tick),
    .cfg_err   (cfg_err)
  );

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_reset();
    repeat (3) @(negedge clk);
    chk_eq("R9", "bclk in reset", int'(bclk), 0);
    chk_eq("R9", "mclk in reset", int'(mclk), 0);
    chk_eq("R9", "bit_tick in reset", int'(bit_tick), 0);
    chk_eq("R9", "cfg_err in reset", int'(cfg_err), 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // one scenario: configure while idle, enable, measure one bit-clock period
  task automatic run_case(input int dv, input bit od, input bit me, input bit lc);
    int d, n, k, exp_hi, exp_lo, exp_mhi;
    int lat, hi, lo, mhi, ticks, tick_first, guard;
    string rq;
    d  = (dv < 2) ? 2 : dv;
    n  = 2 * d + int'(od);
    k  = me ? (lc ? 4 : 8) : 1;
    rq = !me ? (od ? "R2" : "R1") : (lc ? "R4" : "R3");
    exp_hi  = me ? (k / 2) * n : d + int'(od);
    exp_lo  = me ? (k / 2) * n : d;
    exp_mhi = me ? k * (d + int'(od)) : 0;

    en = 1'b0; div_val = 8'(dv); odd_ratio = od; mck_on = me; long_chan = lc;
    repeat (2) @(negedge clk);
    en = 1'b1;
    lat = 0; guard = 0;
    do begin
      @(negedge clk);
      lat++;
      guard++;
    end while (!bclk && guard < 5000);
    chk_eq("R6", $sformatf("first bclk rise div=%0d odd=%0d mck=%0d", dv, od, me), lat, n);
    if (me) chk_eq("R6", "mclk rises with first bclk", int'(mclk), 1);
    tick_first = int'(bit_tick);
    chk_eq("R7", "tick at bclk rise", tick_first, 1);
    hi = 0; lo = 0; mhi = 0; ticks = 0; guard = 0;
    while (bclk && guard < 5000) begin
      hi++; mhi += int'(mclk); ticks += int'(bit_tick); guard++;
      @(negedge clk);
    end
    while (!bclk && guard < 5000) begin
      lo++; mhi += int'(mclk); ticks += int'(bit_tick); guard++;
      @(negedge clk);
    end
    chk_eq(rq, $sformatf("bclk high div=%0d odd=%0d mck=%0d lc=%0d", dv, od, me, lc), hi, exp_hi);
    chk_eq(rq, $sformatf("bclk low div=%0d odd=%0d mck=%0d lc=%0d", dv, od, me, lc), lo, exp_lo);
    chk_eq("R5", "mclk high cycles over one bclk period", mhi, exp_mhi);
    chk_eq("R7", "ticks per bclk period", ticks, 1);
    chk_eq("R8", "cfg_err", int'(cfg_err), (dv < 2) ? 1 : 0);
    en = 1'b0;
    @(negedge clk);
    chk_eq("R9", "bclk after disable", int'(bclk), 0);
    chk_eq("R9", "mclk after disable", int'(mclk), 0);
    chk_eq("R9", "cfg_err after disable", int'(cfg_err), 0);
  endtask

  // master-clock phases measured directly for an odd ratio
  task automatic mclk_phase_case();
    int hi, lo, guard;
    en = 1'b0; div_val = 8'd3; odd_ratio = 1'b1; mck_on = 1'b1; long_chan = 1'b1;
    repeat (2) @(negedge clk);
    en = 1'b1;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!mclk && guard < 5000);
    hi = 0; lo = 0;
    while (mclk && guard < 5000) begin hi++; guard++; @(negedge clk); end
    while (!mclk && guard < 5000) begin lo++; guard++; @(negedge clk); end
    chk_eq("R5", "mclk high phase", hi, 4);
    chk_eq("R5", "mclk low phase", lo, 3);
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL R6 watchdog expired: actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    check_reset();
    run_case(3,   1'b0, 1'b0, 1'b0);
    run_case(3,   1'b1, 1'b0, 1'b1);
    run_case(255, 1'b1, 1'b0, 1'b0);
    run_case(4,   1'b1, 1'b1, 1'b0);
    run_case(2,   1'b0, 1'b1, 1'b1);
    run_case(5,   1'b1, 1'b1, 1'b1);
    run_case(6,   1'b0, 1'b1, 1'b0);
    run_case(0,   1'b1, 1'b0, 1'b0);
    run_case(1,   1'b0, 1'b1, 1'b0);
    mclk_phase_case();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule